// File: doc/BRIEF.md
# Serial EEPROM Page-Write Address Controller

This block stands behind a two-wire serial slave engine and models the storage side of a small serial EEPROM. It keeps a word-address counter that persists between transactions. It collects the bytes of a write sequence in a one-page buffer. When a STOP arrives, it commits that buffer to an internal byte array and then runs a timed write cycle, during which it reports busy and ignores every strobe.

The slave engine drives single-cycle strobes. The strobes are: load an address, write a byte, request a read byte, and STOP. The engine also passes the level of the write-protect pin through. If two strobes arrive in the same cycle, an address load takes priority over a byte write, and a byte write takes priority over a read request.

The array size is PAGES × PAGE_BYTES, and both must be powers of two. Serial bit timing is not part of this block. The write-cycle length is a parameter in clock cycles. A parameter chooses whether write protect covers the whole array or only its upper half.

Top module: `eep_page_ctl`

## Requirements
- R1: After reset, busy_o is 0, rd_data_o is 0x00, the address counter is 0 and every array byte reads as 0x00.
- R2: A read request, accepted while idle, places the array byte at the counter address on rd_data_o in the next cycle and advances the counter by one. An address load sets the counter, and a read with no load continues from the last accessed address plus one.
- R3: During reads, the whole counter increments. After the last address (all ones), it wraps to address 0.
- R4: Each accepted byte write goes to the counter address. After it, only the low log2(PAGE_BYTES) counter bits increment, and the page-row bits above them do not change. More than PAGE_BYTES bytes in one sequence therefore wrap to the start of the same page and overwrite earlier bytes.
- R5: Written bytes reach the array only at STOP, so reads before the STOP return the old contents. Bytes of the page that were not written in the sequence keep their previous values.
- R6: A STOP that follows at least one accepted data byte, with the page not protected, raises busy_o in the cycle after the STOP. busy_o stays high for exactly WR_CYCLES cycles.
- R7: While busy_o is high, address loads, byte writes, read requests and STOP strobes have no effect: the counter, the array and rd_data_o stay unchanged.
- R8: A STOP with no data byte since the last address load or STOP writes nothing and leaves busy_o low.
- R9: With WP_UPPER_HALF = 0 and wp_i high at STOP, nothing is written anywhere and busy_o stays low.
- R10: With WP_UPPER_HALF = 1 and wp_i high at STOP, the write is blocked (no change, no busy) only when the page row's most significant bit is 1. Pages in the lower half are written normally.
- R11: With wp_i low at STOP, a write to any page is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_load_i | input | 1 | Load the word-address counter and start a new sequence |
| addr_i | input | AW | Word address to load (AW = log2(PAGES*PAGE_BYTES)) |
| wr_i | input | 1 | Store one data byte into the page buffer |
| wr_data_i | input | 8 | Data byte for wr_i |
| rd_req_i | input | 1 | Fetch the byte at the counter address |
| stop_i | input | 1 | STOP seen on the bus; commits a pending page |
| wp_i | input | 1 | Write-protect pin level |
| rd_data_o | output | 8 | Last fetched read byte |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
A counter that wraps across the page row during writes does not show up at commit time. It shows at the first current-address read or the next commit, because bytes land in a neighbouring page. A counter that wraps within the page during reads instead of across the array shows within one read of the page end. A buffer that drops its valid mask, or commits unwritten slots, corrupts bytes that were never touched; the next read of those bytes exposes it. A wrong busy length or a leaky ignore gate shows up as a busy run of the wrong length, or as a read returning from an address the bench never loaded.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr #(
  parameter int AW = 7,
  parameter int OW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          step_page_i,
  input  logic          step_full_i,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          addr_o <= '0;
    else if (load_i)      addr_o <= load_addr_i;
    else if (step_page_i) addr_o[OW-1:0] <= addr_o[OW-1:0] + OW'(1);
    else if (step_full_i) addr_o <= addr_o + AW'(1);
  end
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf
  import eep_pkg::*;
#(
  parameter int PAGE_BYTES = 8,
  parameter int OW = 3,
  parameter int RW = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clr_i,
  input  logic                        wr_i,
  input  logic [OW-1:0]               off_i,
  input  logic [RW-1:0]               row_i,
  input  byte_t                       data_i,
  output logic [PAGE_BYTES-1:0][7:0]  data_o,
  output logic [PAGE_BYTES-1:0]       mask_o,
  output logic [RW-1:0]               row_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      mask_o <= '0;
      row_o  <= '0;
    end else if (clr_i) begin
      mask_o <= '0;
    end else if (wr_i) begin
      data_o[off_i] <= data_i;
      mask_o[off_i] <= 1'b1;
      row_o         <= row_i;
    end
  end
endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
  parameter int WR_CYCLES = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= CW'(WR_CYCLES);
    else if (cnt_q != '0)      cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/eep_page_ctl.sv
module eep_page_ctl
  import eep_pkg::*;
#(
  parameter int PAGES         = 16,
  parameter int PAGE_BYTES    = 8,
  parameter int WR_CYCLES     = 12,
  parameter bit WP_UPPER_HALF = 1'b0,
  localparam int DEPTH        = PAGES * PAGE_BYTES,
  localparam int AW           = $clog2(DEPTH),
  localparam int OW           = $clog2(PAGE_BYTES),
  localparam int RW           = AW - OW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_load_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          rd_req_i,
  input  logic          stop_i,
  input  logic          wp_i,
  output logic [7:0]    rd_data_o,
  output logic          busy_o
);
  logic                        idle;
  logic                        ld_acc, wr_acc, rd_acc, stop_acc;
  logic                        prot, commit;
  logic [AW-1:0]               addr_q;
  logic [PAGE_BYTES-1:0][7:0]  buf_data;
  logic [PAGE_BYTES-1:0]       buf_mask;
  logic [RW-1:0]               buf_row;
  byte_t                       mem [DEPTH];

  assign idle     = !busy_o;
  assign ld_acc   = addr_load_i & idle;
  assign wr_acc   = wr_i & idle & !addr_load_i;
  assign rd_acc   = rd_req_i & idle & !addr_load_i & !wr_i;
  assign stop_acc = stop_i & idle;

  generate
    if (WP_UPPER_HALF) begin : g_prot_half
      assign prot = wp_i & buf_row[RW-1];
    end else begin : g_prot_full
      assign prot = wp_i;
    end
  endgenerate

  assign commit = stop_acc & (|buf_mask) & !prot;

  eep_addr_ctr #(.AW(AW), .OW(OW)) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (ld_acc),
    .load_addr_i (addr_i),
    .step_page_i (wr_acc),
    .step_full_i (rd_acc),
    .addr_o      (addr_q)
  );

  eep_page_buf #(.PAGE_BYTES(PAGE_BYTES), .OW(OW), .RW(RW)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ld_acc | stop_acc),
    .wr_i   (wr_acc),
    .off_i  (addr_q[OW-1:0]),
    .row_i  (addr_q[AW-1:OW]),
    .data_i (wr_data_i),
    .data_o (buf_data),
    .mask_o (buf_mask),
    .row_o  (buf_row)
  );

  eep_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (commit),
    .busy_o  (busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_data_o <= '0;
    end else begin
      if (rd_acc) rd_data_o <= mem[addr_q];
      if (commit) begin
        for (int i = 0; i < PAGE_BYTES; i++)
          if (buf_mask[i]) mem[{buf_row, OW'(i)}] <= buf_data[i];
      end
    end
  end
endmodule

// File: rtl/eep_page_ctl_chk.sv
module eep_page_ctl_chk #(
  parameter int AW         = 7,
  parameter int OW         = 3,
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 12
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  addr_load_i,
  input logic                  wr_i,
  input logic                  rd_req_i,
  input logic                  stop_i,
  input logic                  busy_o,
  input logic [7:0]            rd_data_o,
  input logic [AW-1:0]         addr_q,
  input logic [PAGE_BYTES-1:0] buf_mask
);
  localparam int CW = $clog2(WR_CYCLES + 2);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + CW'(1);
    else             run_q <= '0;
  end

  p_busy_max_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_q < CW'(WR_CYCLES)));

  p_busy_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == CW'(WR_CYCLES)));

  p_busy_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(stop_i) && ($past(buf_mask) != '0)));

  p_empty_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !busy_o && buf_mask == '0) |=> !busy_o);

  p_rd_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(rd_data_o));

  p_addr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(addr_q));

  p_page_row_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !busy_o && !addr_load_i) |=> (addr_q[AW-1:OW] == $past(addr_q[AW-1:OW])));

  p_rd_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !busy_o && !addr_load_i && !wr_i && (&addr_q)) |=> (addr_q == '0));
endmodule

bind eep_page_ctl eep_page_ctl_chk #(
  .AW(AW), .OW(OW), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_load_i (addr_load_i),
  .wr_i        (wr_i),
  .rd_req_i    (rd_req_i),
  .stop_i      (stop_i),
  .busy_o      (busy_o),
  .rd_data_o   (rd_data_o),
  .addr_q      (addr_q),
  .buf_mask    (buf_mask)
);

// File: tb/eep_page_ctl_tb_top.sv
module eep_page_ctl_tb_top;
  localparam int PAGES = 16;
  localparam int PB    = 8;
  localparam int W     = 12;
  localparam int DEPTH = PAGES * PB;
  localparam int AW    = 7;
  localparam int OW    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          addr_load = 0, wr = 0, rd_req = 0, stop = 0, wp = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rd0, rd1;
  logic          busy0, busy1;

  eep_page_ctl #(.PAGES(PAGES), .PAGE_BYTES(PB), .WR_CYCLES(W), .WP_UPPER_HALF(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_load_i(addr_load), .addr_i(addr), .wr_i(wr),
    .wr_data_i(wdata), .rd_req_i(rd_req), .stop_i(stop), .wp_i(wp),
    .rd_data_o(rd0), .busy_o(busy0));

  eep_page_ctl #(.PAGES(PAGES), .PAGE_BYTES(PB), .WR_CYCLES(W), .WP_UPPER_HALF(1'b1)) dut_half_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_load_i(addr_load), .addr_i(addr), .wr_i(wr),
    .wr_data_i(wdata), .rd_req_i(rd_req), .stop_i(stop), .wp_i(wp),
    .rd_data_o(rd1), .busy_o(busy1));

  int checks = 0;
  int errors = 0;
  logic [7:0]    e0 [DEPTH];
  logic [7:0]    e1 [DEPTH];
  logic [7:0]    pd [PB];
  logic [PB-1:0] pm;
  logic [AW-1:0] ec;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(logic [AW-1:0] a);
    @(negedge clk); addr_load = 1; addr = a;
    @(negedge clk); addr_load = 0;
    ec = a; pm = '0;
  endtask

  task automatic do_wr(logic [7:0] b);
    logic [OW-1:0] off;
    @(negedge clk); wr = 1; wdata = b;
    @(negedge clk); wr = 0;
    off = ec[OW-1:0];
    pd[off] = b; pm[off] = 1'b1;
    ec = {ec[AW-1:OW], OW'(off + 1)};
  endtask

  task automatic do_rd(string req);
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0;
    chk(req, rd0, e0[ec]);
    chk(req, rd1, e1[ec]);
    ec = ec + 1'b1;
  endtask

  // poke: drive strobes while busy (R7)
  task automatic do_stop(logic wpv, string req, bit poke);
    logic b0, b1;
    logic [AW-OW-1:0] row;
    int n0, n1;
    logic [7:0] h0;
    row = ec[AW-1:OW];
    b0 = (pm != '0) && !wpv;
    b1 = (pm != '0) && !(wpv && row[AW-OW-1]);
    for (int i = 0; i < PB; i++) if (pm[i]) begin
      if (b0) e0[{row, OW'(i)}] = pd[i];
      if (b1) e1[{row, OW'(i)}] = pd[i];
    end
    pm = '0;
    h0 = rd0;
    @(negedge clk); stop = 1; wp = wpv;
    @(negedge clk); stop = 0;
    n0 = 0; n1 = 0;
    for (int k = 0; k < W + 3; k++) begin
      n0 += busy0; n1 += busy1;
      if (poke) begin
        addr_load = (k == 1); addr = 7'd3;
        wr = (k == 2); wdata = 8'hAA;
        rd_req = (k == 3);
        stop = (k == 4);
      end
      @(negedge clk);
    end
    addr_load = 0; wr = 0; rd_req = 0; stop = 0; wp = 0;
    chk(req, n0, b0 ? W : 0);
    chk(req, n1, b1 ? W : 0);
    if (poke) chk("R7 rd_data held", rd0, h0);
  endtask

  task automatic fill_page(logic [AW-1:0] base, logic [7:0] seed);
    do_load(base);
    for (int i = 0; i < PB; i++) do_wr(seed + 8'(i));
    do_stop(1'b0, "R11 commit", 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) begin e0[i] = 0; e1[i] = 0; end
    pm = '0; ec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 busy", busy0, 0);
    chk("R1 rd_data", rd0, 0);
    do_rd("R1 counter zero read");
    // R2 current address continues
    do_rd("R2 current read");
    do_load(7'd33);
    do_rd("R2 loaded read");
    // R4 over-page write at offset 5, page 0
    do_load(7'd5);
    for (int i = 0; i < 10; i++) do_wr(8'h40 + 8'(i));
    do_stop(1'b0, "R6 busy length", 0);
    do_load(7'd0);
    for (int i = 0; i < PB; i++) do_rd("R4 page wrap contents");
    do_load(7'd5); do_rd("R4 overwrite");
    chk("R4 wrapped byte", rd0, 8'h48);
    // R5 partial page keeps untouched bytes
    fill_page(7'd16, 8'h10);
    do_load(7'd18);
    do_wr(8'hC3);
    do_rd("R5 read before stop old");
    do_stop(1'b0, "R6 busy partial", 0);
    do_load(7'd16);
    for (int i = 0; i < PB; i++) do_rd("R5 partial page");
    // R8 address only
    do_load(7'd50);
    do_stop(1'b0, "R8 no busy", 0);
    do_rd("R8 no change");
    // R3 read wrap
    do_load(7'd127);
    do_rd("R3 last"); do_rd("R3 wrap zero"); do_rd("R3 after wrap");
    // R7 strobes during busy
    do_load(7'd40);
    do_wr(8'h77); do_wr(8'h78);
    do_stop(1'b0, "R6 busy before poke", 1);
    do_rd("R7 counter unchanged");
    do_load(7'd0); do_rd("R7 array unchanged");
    // R9/R10 protect lower and upper page
    do_load(7'd8); do_wr(8'h5A); do_wr(8'h5B);
    do_stop(1'b1, "R9 R10 lower page", 0);
    do_load(7'd8); do_rd("R10 lower written"); do_rd("R9 lower blocked");
    do_load(7'd100); do_wr(8'h99);
    do_stop(1'b1, "R9 R10 upper page", 0);
    do_load(7'd100); do_rd("R10 upper blocked");
    // R11 wp low upper page
    do_load(7'd120); do_wr(8'hE1);
    do_stop(1'b0, "R11 wp low", 0);
    do_load(7'd120); do_rd("R11 written");
    // random mix
    for (int it = 0; it < 150; it++) begin
      if ($urandom % 2 == 0) begin
        int n;
        logic wpv;
        do_load(AW'($urandom));
        n = $urandom % 20;
        for (int j = 0; j < n; j++) do_wr(8'($urandom));
        wpv = ($urandom % 3 == 0);
        do_stop(wpv, "R6 R9 R10 R11 random write", 0);
      end else begin
        int m;
        if ($urandom % 3 != 0) do_load(AW'($urandom));
        m = 1 + $urandom % 10;
        for (int j = 0; j < m; j++) do_rd("R2 R3 random read");
        do_stop(1'b0, "R8 stop after read", 0);
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule